// File: doc/BRIEF.md
# Unified Partial-Tag Translation Cache

This block is a small, fully associative cache that sits beside a page walker for a four-level radix page table. Instead of caching page-table entries by their physical address, each slot is keyed by a prefix of the virtual-address index fields. A slot can cover one, two or three upper levels, and the lower fields it does not cover are ignored in the compare. A lookup returns the deepest level that any slot covers for the requested address, together with the stored physical frame pointer of the next table page. The walker then starts its memory references at the level below that one and skips the levels above it. After a deep hit, only the leaf reference remains.

The walker writes the cache through a fill port after each upper-level memory reference. It supplies the address, the depth the entry covers and the pointer it read. Slots of all three depths share one pool. An external replacement controller names the victim slot, which is used only when no slot is free. A flush input empties the cache.

Each cycle, a write action is chosen from the flush and fill inputs. IDLE applies when there is no flush and no usable fill. FLUSH applies whenever flush is high. UPDATE applies to a fill whose depth and prefix already sit in a slot. FREE applies to a fill when a slot is invalid. EVICT applies to a fill when every slot is valid. In all other cases the next cycle returns to IDLE, because every action lasts one cycle.

Top module: `uptc_xlat_cache`

## Requirements
- R1: The virtual address has 48 bits: the top-level index is bits 47:39, the second-level index is bits 38:30, the third-level index is bits 29:21, and bits 20:0 are never compared. A lookup request (`lk_req`) produces `rsp_valid` exactly one cycle later. Without a request, `rsp_valid` stays low.
- R2: Depth codes are 0 = none, 1 = top level only, 2 = top two levels, 3 = top three levels. A slot of depth k compares only the k highest index fields and ignores the rest of the address.
- R3: When several slots match a lookup, the response carries the greatest depth among them and that slot's pointer.
- R4: On a miss, `rsp_hit`, `rsp_level` and `rsp_ptr` are all zero.
- R5: A fill with depth code 0 changes nothing.
- R6: A fill whose depth and covered prefix equal an existing slot's overwrites that slot's pointer and does not take a second slot.
- R7: A fill with no matching slot goes to the lowest-numbered invalid slot while one exists, whatever `repl_way` says.
- R8: When every slot is valid, a new fill replaces the slot numbered by `repl_way`.
- R9: A flush invalidates every slot in one cycle and takes priority over a fill in the same cycle.
- R10: A lookup sees the contents from before any fill or flush applied in the same cycle.
- R11: After reset, every slot is invalid and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Some slot matched |
| rsp_level | output | 2 | Deepest matched depth code |
| rsp_ptr | output | 40 | Next-level table pointer |
| fill_req | input | 1 | Fill request |
| fill_va | input | 48 | Fill virtual address |
| fill_level | input | 2 | Depth code of the fill |
| fill_ptr | input | 40 | Pointer to store |
| repl_way | input | 3 | Victim slot from the replacement controller |
| flush | input | 1 | Invalidate all slots |

## Verification
The assertions check the timing rules that apply in every cycle. A response follows each request exactly one cycle later and at no other time. A miss carries zeros, and a hit carries a nonzero depth. The slot valid vector is empty in the cycle after a flush, and a lookup issued in that cycle misses. Only the bench's scenarios can show the behaviour that depends on stored contents. These cover the choice of the deepest match among overlapping prefixes, the don't-care treatment of lower fields, and in-place update instead of duplication. They also cover the preference for free slots over the victim input, eviction when the cache is full, the ordering between same-cycle lookup, fill and flush, and the rejection of depth-zero fills.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_TOP  = 2'd1,
        LVL_MID  = 2'd2,
        LVL_LOW  = 2'd3
    } tc_level_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_FLUSH,
        ACT_UPDATE,
        ACT_FREE,
        ACT_EVICT
    } tc_act_e;

    // Compare mask for a prefix of three index fields, aligned at bit 0.
    // Depth d enables the d highest fields. Index width at most 21.
    function automatic logic [63:0] level_mask(input int idx_w, input logic [1:0] lvl);
        logic [63:0] m;
        m = '0;
        for (int k = 0; k < 3; k++) begin
            for (int b = 0; b < 21; b++) begin
                if (b < idx_w && k < int'(lvl)) begin
                    m[6'((2 - k) * idx_w + b)] = 1'b1;
                end
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/tc_match.sv
module tc_match
    import tc_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 9,
    parameter bit EXACT = 1'b0
) (
    input  logic [3*IDX_W-1:0]         key,
    input  logic [1:0]                 key_lvl,
    input  logic [N-1:0]               ent_valid,
    input  logic [N-1:0][1:0]          ent_lvl,
    input  logic [N-1:0][3*IDX_W-1:0]  ent_tag,
    output logic [N-1:0]               hit
);
    localparam int PFX_W = 3 * IDX_W;

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [PFX_W-1:0] m;
        logic             tag_eq;
        assign m      = PFX_W'(level_mask(IDX_W, ent_lvl[i]));
        assign tag_eq = ((key & m) == ent_tag[i]);
        if (EXACT) begin : g_exact
            // Same depth and same covered prefix: used to find a fill duplicate
            assign hit[i] = ent_valid[i] && (ent_lvl[i] == key_lvl) && tag_eq;
        end else begin : g_prefix
            // Any slot no deeper than key_lvl whose covered prefix agrees
            assign hit[i] = ent_valid[i] && (ent_lvl[i] != 2'd0)
                            && (ent_lvl[i] <= key_lvl) && tag_eq;
        end
    end

endmodule

// File: rtl/tc_select.sv
module tc_select #(
    parameter int N     = 8,
    parameter int PTR_W = 40
) (
    input  logic [N-1:0]             hit,
    input  logic [N-1:0][1:0]        ent_lvl,
    input  logic [N-1:0][PTR_W-1:0]  ent_ptr,
    output logic                     best_hit,
    output logic [1:0]               best_lvl,
    output logic [PTR_W-1:0]         best_ptr
);
    always_comb begin
        best_lvl = 2'd0;
        best_ptr = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i] && ent_lvl[i] > best_lvl) begin
                best_lvl = ent_lvl[i];
                best_ptr = ent_ptr[i];
            end
        end
        best_hit = (best_lvl != 2'd0);
    end

endmodule

// File: rtl/tc_alloc.sv
module tc_alloc #(
    parameter int N     = 8,
    parameter int WAY_W = 3
) (
    input  logic [N-1:0]     ent_valid,
    input  logic [N-1:0]     dup,
    output logic             has_dup,
    output logic [WAY_W-1:0] dup_way,
    output logic             has_free,
    output logic [WAY_W-1:0] free_way
);
    always_comb begin
        has_dup  = 1'b0;
        dup_way  = '0;
        has_free = 1'b0;
        free_way = '0;
        // Scan downward so the lowest index is the one left standing
        for (int i = N - 1; i >= 0; i--) begin
            if (dup[i]) begin
                has_dup = 1'b1;
                dup_way = WAY_W'(i);
            end
            if (!ent_valid[i]) begin
                has_free = 1'b1;
                free_way = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/uptc_xlat_cache.sv
module uptc_xlat_cache
    import tc_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 9,
    parameter int OFF_W = 12,
    parameter int PTR_W = 40,
    localparam int VA_W  = OFF_W + 4 * IDX_W,
    localparam int WAY_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_level,
    output logic [PTR_W-1:0]  rsp_ptr,
    input  logic              fill_req,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [1:0]        fill_level,
    input  logic [PTR_W-1:0]  fill_ptr,
    input  logic [WAY_W-1:0]  repl_way,
    input  logic              flush
);
    localparam int PFX_W   = 3 * IDX_W;
    localparam int PFX_LSB = OFF_W + IDX_W;

    // Slot storage
    logic [N-1:0]              ent_valid;
    logic [N-1:0][1:0]         ent_lvl;
    logic [N-1:0][PFX_W-1:0]   ent_tag;
    logic [N-1:0][PTR_W-1:0]   ent_ptr;

    // Prefixes; the leaf index and page offset never enter a compare
    logic [PFX_W-1:0] lk_pfx;
    logic [PFX_W-1:0] fill_pfx;
    logic [PFX_W-1:0] fill_tag_m;
    logic             unused_low;

    assign lk_pfx     = lk_va[PFX_LSB +: PFX_W];
    assign fill_pfx   = fill_va[PFX_LSB +: PFX_W];
    assign fill_tag_m = fill_pfx & PFX_W'(level_mask(IDX_W, fill_level));
    assign unused_low = ^{lk_va[PFX_LSB-1:0], fill_va[PFX_LSB-1:0]};

    // Lookup path
    logic [N-1:0]     lk_hit;
    logic             sel_hit;
    logic [1:0]       sel_lvl;
    logic [PTR_W-1:0] sel_ptr;

    tc_match #(.N(N), .IDX_W(IDX_W), .EXACT(1'b0)) u_lk_match (
        .key       (lk_pfx),
        .key_lvl   (LVL_LOW),
        .ent_valid (ent_valid),
        .ent_lvl   (ent_lvl),
        .ent_tag   (ent_tag),
        .hit       (lk_hit)
    );

    tc_select #(.N(N), .PTR_W(PTR_W)) u_select (
        .hit      (lk_hit),
        .ent_lvl  (ent_lvl),
        .ent_ptr  (ent_ptr),
        .best_hit (sel_hit),
        .best_lvl (sel_lvl),
        .best_ptr (sel_ptr)
    );

    // Fill path
    logic [N-1:0]     fill_dup;
    logic             has_dup;
    logic             has_free;
    logic [WAY_W-1:0] dup_way;
    logic [WAY_W-1:0] free_way;

    tc_match #(.N(N), .IDX_W(IDX_W), .EXACT(1'b1)) u_fill_match (
        .key       (fill_tag_m),
        .key_lvl   (fill_level),
        .ent_valid (ent_valid),
        .ent_lvl   (ent_lvl),
        .ent_tag   (ent_tag),
        .hit       (fill_dup)
    );

    tc_alloc #(.N(N), .WAY_W(WAY_W)) u_alloc (
        .ent_valid (ent_valid),
        .dup       (fill_dup),
        .has_dup   (has_dup),
        .dup_way   (dup_way),
        .has_free  (has_free),
        .free_way  (free_way)
    );

    // Write action selection
    tc_act_e          act;
    logic [WAY_W-1:0] tgt;

    always_comb begin
        act = ACT_IDLE;
        tgt = '0;
        if (flush) begin
            act = ACT_FLUSH;
        end else if (fill_req && fill_level != LVL_NONE) begin
            if (has_dup) begin
                act = ACT_UPDATE;
                tgt = dup_way;
            end else if (has_free) begin
                act = ACT_FREE;
                tgt = free_way;
            end else begin
                act = ACT_EVICT;
                tgt = repl_way;
            end
        end
    end

    // Storage update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_lvl   <= '0;
            ent_tag   <= '0;
            ent_ptr   <= '0;
        end else begin
            unique case (act)
                ACT_FLUSH: begin
                    ent_valid <= '0;
                end
                ACT_UPDATE: begin
                    ent_ptr[tgt] <= fill_ptr;
                end
                ACT_FREE, ACT_EVICT: begin
                    ent_valid[tgt] <= 1'b1;
                    ent_lvl[tgt]   <= fill_level;
                    ent_tag[tgt]   <= fill_tag_m;
                    ent_ptr[tgt]   <= fill_ptr;
                end
                default: begin
                end
            endcase
        end
    end

    // Response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_level <= 2'd0;
            rsp_ptr   <= '0;
        end else begin
            rsp_valid <= lk_req;
            if (lk_req) begin
                rsp_hit   <= sel_hit;
                rsp_level <= sel_lvl;
                rsp_ptr   <= sel_ptr;
            end else begin
                rsp_hit   <= 1'b0;
                rsp_level <= 2'd0;
                rsp_ptr   <= '0;
            end
        end
    end

endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
    parameter int N     = 8,
    parameter int PTR_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [1:0]       rsp_level,
    input logic [PTR_W-1:0] rsp_ptr,
    input logic             flush,
    input logic [N-1:0]     ent_valid
);
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    a_r1_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    a_r4_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_level == 2'd0 && rsp_ptr == '0));

    a_r2_hit_has_depth: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && rsp_level != 2'd0));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0));

    a_r9_lookup_after_flush_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (flush ##1 lk_req) |=> !rsp_hit);

endmodule

bind uptc_xlat_cache tc_checker #(.N(N), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_level (rsp_level),
    .rsp_ptr   (rsp_ptr),
    .flush     (flush),
    .ent_valid (ent_valid)
);

// File: tb/sim_uptc_xlat_cache.sv
`timescale 1ns/1ps
module sim_uptc_xlat_cache;

    localparam int N     = 4;
    localparam int PTR_W = 40;

    typedef struct {
        bit              hit;
        logic [1:0]      lvl;
        logic [PTR_W-1:0] ptr;
        string           tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_req = 1'b0;
    logic [47:0]       lk_va = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [1:0]        rsp_level;
    logic [PTR_W-1:0]  rsp_ptr;
    logic              fill_req = 1'b0;
    logic [47:0]       fill_va = '0;
    logic [1:0]        fill_level = '0;
    logic [PTR_W-1:0]  fill_ptr = '0;
    logic [1:0]        repl_way = '0;
    logic              flush = 1'b0;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    always #4 clk = ~clk;

    uptc_xlat_cache #(.N(N), .PTR_W(PTR_W)) u0 (
        .clk, .rst_n, .lk_req, .lk_va, .rsp_valid, .rsp_hit, .rsp_level,
        .rsp_ptr, .fill_req, .fill_va, .fill_level, .fill_ptr, .repl_way, .flush
    );

    function automatic logic [47:0] mkva(int a, int b, int c, int d, int off);
        return {a[8:0], b[8:0], c[8:0], d[8:0], off[11:0]};
    endfunction

    task automatic check(bit ok, string tag, string act, string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic expect_rsp(bit h, logic [1:0] l, logic [PTR_W-1:0] p, string tag);
        exp_t e;
        e.hit = h; e.lvl = l; e.ptr = p; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic lookup(logic [47:0] va, bit h, logic [1:0] l,
                          logic [PTR_W-1:0] p, string tag);
        lk_req = 1'b1;
        lk_va  = va;
        expect_rsp(h, l, p, tag);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic fill(logic [47:0] va, logic [1:0] l, logic [PTR_W-1:0] p);
        fill_req   = 1'b1;
        fill_va    = va;
        fill_level = l;
        fill_ptr   = p;
        @(negedge clk);
        fill_req = 1'b0;
    endtask

    // Monitor: compare each response with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R1 stray response", "rsp_valid=1", "rsp_valid=0");
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(rsp_hit == e.hit && rsp_level == e.lvl && rsp_ptr == e.ptr, e.tag,
                      $sformatf("hit=%0d lvl=%0d ptr=%h", rsp_hit, rsp_level, rsp_ptr),
                      $sformatf("hit=%0d lvl=%0d ptr=%h", e.hit, e.lvl, e.ptr));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R11 rsp_valid in reset", $sformatf("%0d", rsp_valid), "0");
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 rsp_valid after reset", $sformatf("%0d", rsp_valid), "0");

        lookup(mkva(5, 7, 9, 1, 0), 0, 0, 0, "R11 empty after reset");
        lookup(mkva(0, 0, 0, 0, 0), 0, 0, 0, "R4 miss zero");

        // R7: repl_way names slot 3 while free slots remain; it must be ignored
        repl_way = 2'd3;
        fill(mkva(5, 'h55, 'h66, 3, 7), 2'd1, 40'h111);   // top only
        fill(mkva(5, 7, 'h1ff, 0, 0), 2'd2, 40'h222);    // top two
        fill(mkva(5, 7, 9, 4, 0), 2'd3, 40'h333);        // top three

        lookup(mkva(5, 7, 9, 'h12, 'h345), 1, 3, 40'h333, "R3 deepest of three");
        lookup(mkva(5, 7, 8, 0, 0), 1, 2, 40'h222, "R2 depth2 ignores third field");
        lookup(mkva(5, 6, 9, 0, 0), 1, 1, 40'h111, "R2 depth1 ignores lower fields");
        lookup(mkva(4, 7, 9, 0, 0), 0, 0, 0, "R1 top field differs miss");
        lookup(mkva(5, 7, 9, 0, 0) ^ 48'h1f_ffff, 1, 3, 40'h333, "R1 low bits ignored");

        // R5: depth zero fill
        fill(mkva(100, 1, 1, 0, 0), 2'd0, 40'h999);
        lookup(mkva(100, 1, 1, 0, 0), 0, 0, 0, "R5 depth0 fill ignored");

        // R6: update in place, then occupy the last free slot
        fill(mkva(5, 7, 9, 0, 0), 2'd3, 40'h444);
        fill(mkva(20, 1, 1, 0, 0), 2'd3, 40'h555);
        lookup(mkva(5, 7, 9, 0, 0), 1, 3, 40'h444, "R6 updated pointer");
        lookup(mkva(20, 1, 1, 0, 0), 1, 3, 40'h555, "R6 no duplicate slot used");
        lookup(mkva(5, 7, 8, 0, 0), 1, 2, 40'h222, "R7 earlier fill kept");

        // R8: full, victim slot 1 (the depth-2 slot)
        repl_way = 2'd1;
        fill(mkva(30, 2, 2, 0, 0), 2'd2, 40'h666);
        lookup(mkva(5, 7, 8, 0, 0), 1, 1, 40'h111, "R8 victim evicted");
        lookup(mkva(30, 2, 'h77, 0, 0), 1, 2, 40'h666, "R8 new entry present");
        lookup(mkva(5, 7, 9, 0, 0), 1, 3, 40'h444, "R8 others kept");

        // R10: lookup and fill in the same cycle
        fill_req = 1'b1; fill_va = mkva(30, 2, 0, 0, 0); fill_level = 2'd2; fill_ptr = 40'h777;
        lookup(mkva(30, 2, 5, 0, 0), 1, 2, 40'h666, "R10 lookup sees old on fill");
        fill_req = 1'b0;
        lookup(mkva(30, 2, 5, 0, 0), 1, 2, 40'h777, "R10 fill visible next cycle");

        // R9/R10: flush, fill and lookup together
        flush = 1'b1;
        fill_req = 1'b1; fill_va = mkva(40, 3, 3, 0, 0); fill_level = 2'd3; fill_ptr = 40'h888;
        lookup(mkva(5, 7, 9, 0, 0), 1, 3, 40'h444, "R10 lookup sees old on flush");
        flush = 1'b0;
        fill_req = 1'b0;
        lookup(mkva(5, 7, 9, 0, 0), 0, 0, 0, "R9 flushed deep entry");
        lookup(mkva(40, 3, 3, 0, 0), 0, 0, 0, "R9 flush beats fill");
        lookup(mkva(30, 2, 5, 0, 0), 0, 0, 0, "R9 flushed mid entry");

        // R7 after flush: victim points at slot 0 but free slots must be used
        repl_way = 2'd0;
        fill(mkva(50, 1, 1, 0, 0), 2'd3, 40'hA01);
        fill(mkva(51, 1, 1, 0, 0), 2'd3, 40'hA02);
        lookup(mkva(50, 1, 1, 0, 0), 1, 3, 40'hA01, "R7 first free slot kept");
        lookup(mkva(51, 1, 1, 0, 0), 1, 3, 40'hA02, "R7 second free slot");

        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R1 every request answered",
              $sformatf("%0d pending", expq.size()), "0 pending");

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule